// File: doc/BRIEF.md
# Bus Error Condition Detector

This block watches a two-wire management bus and the fill level of a byte ring buffer held in memory, and raises four sticky error flags. Two flags come from stuck-low timers, one on the clock line and one on the data line. Each timer counts consecutive cycles in which its line is sampled low, against its own programmable threshold. The other two flags come from space checks on the ring buffer, each tied to a different memory-write event. The almost-full check runs when a data or header write completes. The full check runs whenever a write of a given length is requested.

The line inputs are expected to be already synchronised to `clk`. The ring buffer size is a power of two, given as a base-2 logarithm. Free space is the size minus the occupied count, and the occupied count is the head-minus-tail difference taken modulo the size. Software clears flags with a per-bit write-1-to-clear strobe. A one-cycle event pulse accompanies each flag as it goes from 0 to 1, for use by a separate interrupt stage.

Each line timer is a three-state machine:
- `LT_HIGH`: the line is high and the count is zero.
- `LT_LOW`: the line is low and the count is running.
- `LT_EXPIRED`: the timeout has fired and the line is still low.

The timer takes the transition `LT_HIGH` to `LT_LOW` on a low sample, or goes straight to `LT_EXPIRED` if the threshold is zero. It takes the transition `LT_LOW` to `LT_EXPIRED` on the sample that exceeds the threshold. From either `LT_LOW` or `LT_EXPIRED`, a high sample sends it back to `LT_HIGH`.

Top module: `bus_err_detect`

## Requirements
- R1: Status bit 0 (clock-line timeout) becomes 1 after the clock edge that samples `scl_i` low for the (T+1)-th consecutive time, where T is `scl_thr_i`. It stays 0 while at most T consecutive low samples have been seen.
- R2: Status bit 1 (data-line timeout) follows the rule of R1, using `sda_i` and `sda_thr_i`.
- R3: A high sample restarts a line's count from zero. A line fires at most once per low episode: if its bit is cleared while the line stays low, the bit is not set again until the line has been seen high and then stays low past the threshold again.
- R4: The low-time counters saturate and never wrap. A threshold of 0 fires on the first low sample. The maximum threshold (all ones) fires on the 2^CNT_W-th consecutive low sample.
- R5: On a cycle with `wr_done_i` high, status bit 2 (almost full) is set if free space is below 85 bytes. Free space is 2^L − ((head − tail) mod 2^L), where L is `ring_lg_i`.
- R6: When `wr_done_i` is low, free space has no effect on status bit 2.
- R7: On a cycle with `wr_req_i` high, status bit 3 (full) is set if free space is less than `wr_len_i`. When `wr_req_i` is low, free space has no effect on status bit 3.
- R8: All status bits are 0 after reset. Each set bit stays 1 until a cycle in which its bit of `clr_i` is 1. Clear bits for other positions leave it unchanged.
- R9: If a set condition and a clear for the same bit occur in the same cycle, the bit ends up 1.
- R10: Each bit of `evt_o` is 1 for exactly the one cycle in which the matching status bit has just changed from 0 to 1, and 0 otherwise.
- R11: A `ring_lg_i` value above PTR_W is treated as PTR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronised clock-line level |
| sda_i | input | 1 | Synchronised data-line level |
| scl_thr_i | input | CNT_W | Clock-line low threshold, in cycles |
| sda_thr_i | input | CNT_W | Data-line low threshold, in cycles |
| wr_head_i | input | PTR_W | Ring buffer write (head) pointer |
| rd_tail_i | input | PTR_W | Ring buffer read (tail) pointer |
| ring_lg_i | input | LG_W | Base-2 logarithm of the ring buffer size |
| wr_done_i | input | 1 | Pulse: a data or header write has completed |
| wr_req_i | input | 1 | Pulse: a write of `wr_len_i` bytes is pending |
| wr_len_i | input | PTR_W+1 | Byte length of the pending write |
| clr_i | input | 4 | Write-1-to-clear strobes, one per status bit |
| status_o | output | 4 | Sticky flags: 0 clock-low, 1 data-low, 2 almost full, 3 full |
| evt_o | output | 4 | One-cycle pulse on each 0-to-1 flag transition |

## Verification
Low runs are driven one sample short of the threshold and one sample past it, which separates "more than" from "at least". Runs broken by a single high sample check that the count restarts. A line held low across a clear checks that a timeout fires only once per episode. Thresholds of zero and all ones check the saturation edge. Ring pointer pairs leave exactly 84 and 85 bytes free, and write lengths sit on either side of the free count; these patterns separate the strict comparisons and show which strobe gates which check. A wrap-around pointer pair under an oversized size code checks the clamp. Long random runs, with random thresholds, pointer values, strobes and clears, are then compared every cycle against a bench reference model.

// File: rtl/bus_err_pkg.sv
package bus_err_pkg;
    localparam int NUM_ERR  = 4;
    localparam int ERR_SCL  = 0;
    localparam int ERR_SDA  = 1;
    localparam int ERR_AF   = 2;
    localparam int ERR_FULL = 3;

    typedef enum logic [1:0] {
        LT_HIGH    = 2'd0,
        LT_LOW     = 2'd1,
        LT_EXPIRED = 2'd2
    } line_state_t;
endpackage

// File: rtl/line_low_timer.sv
module line_low_timer
    import bus_err_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             hit_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    line_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LT_HIGH;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        hit_o   = 1'b0;
        unique case (state_q)
            LT_HIGH: begin
                if (!line_i) begin
                    hit_o   = (thr_i == '0);
                    cnt_d   = cnt_inc;
                    state_d = hit_o ? LT_EXPIRED : LT_LOW;
                end
            end
            LT_LOW: begin
                if (line_i) begin
                    cnt_d   = '0;
                    state_d = LT_HIGH;
                end else begin
                    hit_o   = (cnt_q >= thr_i);
                    cnt_d   = cnt_inc;
                    state_d = hit_o ? LT_EXPIRED : LT_LOW;
                end
            end
            LT_EXPIRED: begin
                if (line_i) begin
                    cnt_d   = '0;
                    state_d = LT_HIGH;
                end else begin
                    cnt_d   = cnt_inc;
                end
            end
            default: begin
                cnt_d   = '0;
                state_d = LT_HIGH;
            end
        endcase
    end

    // R1 / R2: a timeout only fires on a low sample
    assert_hit_on_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> !line_i);

    // R3: once expired, no second fire until the line goes high
    assert_once_per_episode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LT_EXPIRED) |-> !hit_o);

    // R4: a low sample never makes the count go down (no wrap)
    assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_i && state_q != LT_HIGH) |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/ring_space_check.sv
module ring_space_check #(
    parameter int PTR_W    = 12,
    parameter int AF_BYTES = 85,
    parameter int LG_W     = $clog2(PTR_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTR_W-1:0] head_i,
    input  logic [PTR_W-1:0] tail_i,
    input  logic [LG_W-1:0]  lg_i,
    input  logic             wr_done_i,
    input  logic             wr_req_i,
    input  logic [PTR_W:0]   wr_len_i,
    output logic             af_hit_o,
    output logic             full_hit_o
);
    localparam logic [LG_W-1:0] LG_MAX  = LG_W'(PTR_W);
    localparam logic [PTR_W:0]  AF_LIM  = (PTR_W+1)'(AF_BYTES);
    localparam logic [PTR_W:0]  ONE_W   = (PTR_W+1)'(1);

    logic [LG_W-1:0] lg_eff;
    logic [PTR_W:0]  size_w, mask_w, diff_w, used_w, free_w;

    always_comb begin
        lg_eff = (lg_i > LG_MAX) ? LG_MAX : lg_i;
        size_w = ONE_W << lg_eff;
        mask_w = size_w - ONE_W;
        diff_w = {1'b0, head_i - tail_i};
        used_w = diff_w & mask_w;
        free_w = size_w - used_w;
    end

    assign af_hit_o   = wr_done_i && (free_w < AF_LIM);
    assign full_hit_o = wr_req_i && (free_w < wr_len_i);

    // R5: free space always lies in 1 .. size
    assert_free_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (free_w != '0) && (free_w <= size_w));
endmodule

// File: rtl/err_status_bank.sv
module err_status_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] status_o,
    output logic [N-1:0] evt_o
);
    logic [N-1:0] st_q, ev_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q[i] <= 1'b0;
                ev_q[i] <= 1'b0;
            end else begin
                st_q[i] <= set_i[i] | (st_q[i] & ~clr_i[i]);
                ev_q[i] <= set_i[i] & ~st_q[i];
            end
        end

        // R9: a set always lands, even alongside a clear
        assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> status_o[i]);
    end

    assign status_o = st_q;
    assign evt_o    = ev_q;

    // R8: uncleared bits hold
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & $past(status_o & ~clr_i)) == $past(status_o & ~clr_i)));

    // R10: event pulses mark exactly the rising flags
    assert_evt_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (evt_o == (status_o & ~$past(status_o))));
endmodule

// File: rtl/bus_err_detect.sv
module bus_err_detect
    import bus_err_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int PTR_W    = 12,
    parameter int AF_BYTES = 85,
    parameter int LG_W     = $clog2(PTR_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [CNT_W-1:0]   scl_thr_i,
    input  logic [CNT_W-1:0]   sda_thr_i,
    input  logic [PTR_W-1:0]   wr_head_i,
    input  logic [PTR_W-1:0]   rd_tail_i,
    input  logic [LG_W-1:0]    ring_lg_i,
    input  logic               wr_done_i,
    input  logic               wr_req_i,
    input  logic [PTR_W:0]     wr_len_i,
    input  logic [NUM_ERR-1:0] clr_i,
    output logic [NUM_ERR-1:0] status_o,
    output logic [NUM_ERR-1:0] evt_o
);
    logic [NUM_ERR-1:0] set_w;
    logic [1:0]         line_w;
    logic [1:0][CNT_W-1:0] thr_w;
    logic [1:0]         line_hit_w;

    assign line_w = {sda_i, scl_i};
    assign thr_w  = {sda_thr_i, scl_thr_i};

    for (genvar k = 0; k < 2; k++) begin : g_line
        line_low_timer #(.CNT_W(CNT_W)) u_timer (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (line_w[k]),
            .thr_i  (thr_w[k]),
            .hit_o  (line_hit_w[k])
        );
    end

    ring_space_check #(
        .PTR_W    (PTR_W),
        .AF_BYTES (AF_BYTES),
        .LG_W     (LG_W)
    ) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_i     (wr_head_i),
        .tail_i     (rd_tail_i),
        .lg_i       (ring_lg_i),
        .wr_done_i  (wr_done_i),
        .wr_req_i   (wr_req_i),
        .wr_len_i   (wr_len_i),
        .af_hit_o   (set_w[ERR_AF]),
        .full_hit_o (set_w[ERR_FULL])
    );

    assign set_w[ERR_SCL] = line_hit_w[0];
    assign set_w[ERR_SDA] = line_hit_w[1];

    err_status_bank #(.N(NUM_ERR)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_w),
        .clr_i    (clr_i),
        .status_o (status_o),
        .evt_o    (evt_o)
    );

    // R6: no write-done, no new almost-full flag
    assert_af_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_done_i && !status_o[ERR_AF]) |=> !status_o[ERR_AF]);

    // R7: no write request, no new full flag
    assert_full_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_req_i && !status_o[ERR_FULL]) |=> !status_o[ERR_FULL]);
endmodule

// File: tb/bus_err_detect_test.sv
module bus_err_detect_test;
    localparam int CNT_W = 16;
    localparam int PTR_W = 12;
    localparam int LG_W  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda = 1'b1;
    logic [CNT_W-1:0] scl_thr = '0, sda_thr = '0;
    logic [PTR_W-1:0] head = '0, tail = '0;
    logic [LG_W-1:0]  lg = 4'd8;
    logic wr_done = 1'b0, wr_req = 1'b0;
    logic [PTR_W:0] wr_len = '0;
    logic [3:0] clr = '0;
    logic [3:0] status, evt;

    int vectors = 0, errors = 0;
    bit done_flag = 0;

    int scl_run = 0, sda_run = 0;
    bit scl_fired = 0, sda_fired = 0;
    logic [3:0] m_st = '0, m_evt = '0;

    always #10 clk = ~clk;

    bus_err_detect #(.CNT_W(CNT_W), .PTR_W(PTR_W)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .scl_thr_i(scl_thr), .sda_thr_i(sda_thr),
        .wr_head_i(head), .rd_tail_i(tail), .ring_lg_i(lg),
        .wr_done_i(wr_done), .wr_req_i(wr_req), .wr_len_i(wr_len),
        .clr_i(clr), .status_o(status), .evt_o(evt)
    );

    function automatic int free_bytes(int h, int t, int l);
        int le, sz, used;
        le = (l > PTR_W) ? PTR_W : l;
        sz = 1 << le;
        used = ((h - t) % sz + sz) % sz;
        return sz - used;
    endfunction

    task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%b expected=%b", tag, got, exp);
        end
    endtask

    // advance one clock with the current inputs, update the model, compare
    task automatic step(string tag);
        logic [3:0] set;
        int fr;
        set = '0;
        if (!scl) begin
            if (!scl_fired && scl_run >= int'(scl_thr)) begin set[0] = 1; scl_fired = 1; end
            scl_run++;
        end else begin scl_run = 0; scl_fired = 0; end
        if (!sda) begin
            if (!sda_fired && sda_run >= int'(sda_thr)) begin set[1] = 1; sda_fired = 1; end
            sda_run++;
        end else begin sda_run = 0; sda_fired = 0; end
        fr = free_bytes(int'(head), int'(tail), int'(lg));
        if (wr_done && fr < 85) set[2] = 1;
        if (wr_req && fr < int'(wr_len)) set[3] = 1;
        m_evt = set & ~m_st;
        m_st  = (m_st & ~clr) | set;
        @(posedge clk);
        @(negedge clk);
        check({tag, " status"}, status, m_st);
        check({tag, " evt R10"}, evt, m_evt);
    endtask

    task automatic idle_inputs();
        wr_done = 0; wr_req = 0; clr = '0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        #(150000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset status", status, 4'b0000);
        check("R8 reset evt", evt, 4'b0000);
        rst_n = 1;
        @(negedge clk);

        // R1: threshold 5, five low samples keep flag 0, sixth sets it
        scl_thr = 16'd5; sda_thr = 16'd7;
        scl = 0;
        for (int i = 0; i < 5; i++) step("R1 below threshold");
        check("R1 not yet", status[0], 1'b0);
        step("R1 crossing");
        check("R1 set", status[0], 1'b1);
        check("R10 pulse", evt[0], 1'b1);
        step("R10 pulse ends");
        check("R10 one cycle", evt[0], 1'b0);

        // R3: clear while still low, must not refire
        clr = 4'b0001; step("R3 clear"); clr = '0;
        for (int i = 0; i < 12; i++) step("R3 held low");
        check("R3 no refire", status[0], 1'b0);
        // R3: broken run restarts count
        scl = 1; step("R3 high");
        scl = 0; for (int i = 0; i < 4; i++) step("R3 short run");
        scl = 1; step("R3 break");
        scl = 0; for (int i = 0; i < 5; i++) step("R3 restarted");
        check("R3 restart", status[0], 1'b0);
        step("R3 refire after high");
        check("R3 second episode", status[0], 1'b1);
        scl = 1; clr = 4'b0001; step("R8 clear"); clr = '0;

        // R2: data line, threshold 7
        sda = 0;
        for (int i = 0; i < 7; i++) step("R2 below threshold");
        check("R2 not yet", status[1], 1'b0);
        step("R2 crossing");
        check("R2 set", status[1], 1'b1);
        sda = 1;
        // R8: clearing another bit leaves bit 1 alone
        clr = 4'b1101; step("R8 other clear"); clr = '0;
        check("R8 kept", status[1], 1'b1);

        // R4: threshold 0 fires on first low sample
        scl_thr = 16'd0; scl = 0; step("R4 zero threshold");
        check("R4 zero", status[0], 1'b1);
        scl = 1; clr = 4'b0011; step("R4 cleanup"); clr = '0;

        // R5/R6: 256-byte ring
        lg = 4'd8; head = 12'd172; tail = 12'd0;   // free 84
        for (int i = 0; i < 3; i++) step("R6 no done");
        check("R6 ignored", status[2], 1'b0);
        wr_done = 1; step("R5 free 84"); wr_done = 0;
        check("R5 set", status[2], 1'b1);
        clr = 4'b0100; step("R5 clear"); clr = '0;
        head = 12'd171;                          // free 85
        wr_done = 1; step("R5 free 85"); wr_done = 0;
        check("R5 boundary", status[2], 1'b0);
        head = 12'd10; tail = 12'd200;           // wrapped, used 66, free 190
        wr_done = 1; step("R5 wrap"); wr_done = 0;

        // R7: full check on write request
        head = 12'd246; tail = 12'd0;            // free 10
        wr_len = 13'd10;
        wr_req = 1; step("R7 fits"); wr_req = 0;
        check("R7 fits", status[3], 1'b0);
        wr_len = 13'd11;
        for (int i = 0; i < 2; i++) step("R7 no req");
        check("R7 ignored", status[3], 1'b0);
        // R9: set and clear in same cycle
        wr_req = 1; clr = 4'b1000; step("R9 set wins"); idle_inputs();
        check("R9 set", status[3], 1'b1);
        clr = 4'b1000; step("R9 cleanup"); clr = '0;

        // R11: size code 15 acts as 12
        lg = 4'd15; head = 12'd5; tail = 12'd10;  // free 5 of 4096
        wr_done = 1; step("R11 clamp"); wr_done = 0;
        check("R11 clamp", status[2], 1'b1);
        clr = 4'b0100; step("R11 cleanup"); clr = '0;

        // R4: maximum threshold, needs 65536 low samples
        scl_thr = 16'hFFFF; scl = 0;
        for (int i = 0; i < 65535; i++) step("R4 long run");
        check("R4 not before max", status[0], 1'b0);
        step("R4 max crossing");
        check("R4 saturate fire", status[0], 1'b1);
        clr = 4'b0001; step("R4 clear"); clr = '0;
        for (int i = 0; i < 20; i++) step("R4 no wrap refire");
        check("R4 no wrap", status[0], 1'b0);
        scl = 1; step("R4 release");

        // random phase
        begin
            int unused;
            unused = $urandom(32'h5eed_1234);
        end
        for (int i = 0; i < 4000; i++) begin
            if (i % 400 == 0) begin
                scl_thr = CNT_W'($urandom_range(0, 10));
                sda_thr = CNT_W'($urandom_range(0, 10));
            end
            if ($urandom_range(0, 7) == 0) scl = ~scl;
            if ($urandom_range(0, 7) == 0) sda = ~sda;
            head    = PTR_W'($urandom);
            tail    = PTR_W'($urandom);
            lg      = LG_W'($urandom_range(0, 15));
            wr_len  = (PTR_W+1)'($urandom_range(0, 300));
            wr_done = ($urandom_range(0, 3) == 0);
            wr_req  = ($urandom_range(0, 3) == 0);
            clr     = 4'($urandom) & 4'($urandom) & 4'($urandom);
            step("R1 R2 R5 R7 R8 R9 random");
        end
        idle_inputs();
        finish_run();
    end
endmodule